// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with a small byte-wide register interface for a host. A single select input chooses between the data path and a control/status path. Bytes written on the data path go into a transmit holding register. They move into a transmit shift register as soon as that shift register is free, so the host can queue the next byte while the current frame is on the line. Incoming frames are assembled in a receive shift register. Each finished byte is copied into a receive holding register, where it waits for the host.

Bit timing comes from a serial tick input, not from the host clock. The tick is a one-cycle enable pulse at the serial clock rate. One bit lasts 1, 16 or 64 ticks, as set by the control word. In the 16x and 64x settings a falling receive line is checked again half a bit later before a frame is accepted. The 1x setting has no such check and samples each bit on a single tick. The block reports transmit-ready, transmit-empty, receive-ready and overrun, and it flags a line held low for a whole frame as a break.

Top module: `uart_xcvr`

## Requirements
- R1: After reset the transmit line is high, the status byte reads 0x05 and the ratio is 16 ticks per bit.
- R2: With `ctrlSel` high, a write loads the control word and a read returns status. Control bits [1:0] pick the ratio: 00 or 01 give 1, 10 gives 16, 11 gives 64. Status bits are bit0 transmit-ready, bit1 receive-ready, bit2 transmit-empty, bit3 overrun and bit4 break, with all other bits zero. With `ctrlSel` low, writes load the transmit holding register and reads return the receive holding register.
- R3: `txReady` is high exactly when the transmit holding register is empty. A held byte moves into the shift register on the first serial tick at which the shift register is empty.
- R4: A transmitted frame is a low start bit, then 8 data bits LSB first, then one high stop bit, each lasting one bit time. The line idles high.
- R5: `txEmpty` stays low from the start of a frame until its stop bit has finished.
- R6: A received byte is copied to the receive holding register and `rxReady` rises on that serial tick. A data read clears `rxReady` and `overrun`.
- R7: In the 16x and 64x ratios, a low pulse on the receive line that has ended by half a bit time after its detection is discarded and produces no byte.
- R8: In the 1x ratio, one tick of low on the receive line is taken as a start bit without any recheck.
- R9: If a byte completes while `rxReady` is still high and no data read happens in that cycle, `overrun` is set and the new byte replaces the old one.
- R10: When the line is low for the whole frame, stop bit included, `breakDet` is set and no byte is delivered. It clears on the first tick at which the line is high again.
- R11: One bit time is exactly 1, 16 or 64 serial ticks for the chosen ratio, independent of the host clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset to idle |
| serTick | input | 1 | One-cycle enable pulse at the serial clock rate |
| ctrlSel | input | 1 | 1 selects control/status, 0 selects data |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data (status or received byte) |
| txLine | output | 1 | Serial transmit line |
| rxLine | input | 1 | Serial receive line (asynchronous) |
| txReady | output | 1 | Transmit holding register empty |
| txEmpty | output | 1 | Transmit shift register idle |
| rxReady | output | 1 | Receive holding register has an unread byte |
| overrun | output | 1 | A received byte was lost |
| breakDet | output | 1 | Break condition on the receive line |

## Verification
Assertions run on every cycle and check the local rules between the flags. A held byte must leave the holding register on a tick once the shifter is idle. An idle transmitter keeps the line high. `rxReady` may rise only on a tick and must drop after a data read. Overrun may only appear while a byte is already waiting. A break must never deliver a byte. The bench scenarios cover what needs whole frames. They show the bit order and bit lengths at each ratio, rejection of a short glitch at mid-bit, acceptance of a one-tick start in 1x mode, the replacement of the byte on overrun, and recovery of the receiver after a break.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  localparam int CntW = 6;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txActive;
    logic rxShift;
    logic rxDeliver;
    logic rxBreakSet;
    logic rxBreakClr;
  } xcvrStrobes_t;

  // last tick index inside one bit for a ratio code
  function automatic logic [CntW-1:0] lastTickOf(input logic [1:0] sel);
    case (sel)
      2'b10:   return CntW'(15);
      2'b11:   return CntW'(63);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/uart_xcvr_ctl.sv
module uart_xcvr_ctl
  import uart_xcvr_pkg::*;
#(
  parameter int DataBits = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serTick,
  input  logic [1:0]   ratioSel,
  input  logic         txHoldFull,
  input  logic         rxSync,
  output xcvrStrobes_t stb
);
  localparam int FrameBits = DataBits + 2;
  localparam int BitsW     = $clog2(FrameBits + 1);
  localparam int IdxW      = $clog2(DataBits);

  logic [CntW-1:0]  lastTick, halfTick;
  logic             txActive;
  logic [CntW-1:0]  txCnt;
  logic [BitsW-1:0] txBitsLeft;
  logic             txAtEnd;
  rxState_t         rxState;
  logic [CntW-1:0]  rxCnt;
  logic [IdxW-1:0]  rxBitIdx;
  logic             rxSawOne;
  logic             rxAtEnd, stopDone;

  always_comb begin
    lastTick = lastTickOf(ratioSel);
    halfTick = lastTick >> 1;
    txAtEnd  = txActive && serTick && (txCnt == lastTick);
    rxAtEnd  = serTick && (rxCnt == lastTick);
    stopDone = (rxState == RX_STOP) && rxAtEnd;
    stb.txLoad     = !txActive && txHoldFull && serTick;
    stb.txShift    = txAtEnd;
    stb.txActive   = txActive;
    stb.rxShift    = (rxState == RX_DATA) && rxAtEnd;
    stb.rxDeliver  = stopDone && (rxSync || rxSawOne);
    stb.rxBreakSet = stopDone && !rxSync && !rxSawOne;
    stb.rxBreakClr = (rxState == RX_BREAK) && serTick && rxSync;
  end

  // transmit bit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive   <= 1'b0;
      txCnt      <= '0;
      txBitsLeft <= '0;
    end else if (stb.txLoad) begin
      txActive   <= 1'b1;
      txCnt      <= '0;
      txBitsLeft <= BitsW'(FrameBits);
    end else if (txAtEnd) begin
      txCnt      <= '0;
      txBitsLeft <= txBitsLeft - BitsW'(1);
      if (txBitsLeft == BitsW'(1)) txActive <= 1'b0;
    end else if (txActive && serTick) begin
      txCnt <= txCnt + CntW'(1);
    end
  end

  // receive frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxCnt    <= '0;
      rxBitIdx <= '0;
      rxSawOne <= 1'b0;
    end else if (serTick) begin
      case (rxState)
        RX_IDLE: if (!rxSync) begin
          rxCnt    <= '0;
          rxBitIdx <= '0;
          rxSawOne <= 1'b0;
          rxState  <= (lastTick == '0) ? RX_DATA : RX_START;
        end
        RX_START: if (rxCnt == halfTick) begin
          rxCnt   <= '0;
          rxState <= rxSync ? RX_IDLE : RX_DATA;
        end else rxCnt <= rxCnt + CntW'(1);
        RX_DATA: if (rxCnt == lastTick) begin
          rxCnt    <= '0;
          rxSawOne <= rxSawOne | rxSync;
          rxBitIdx <= rxBitIdx + IdxW'(1);
          if (rxBitIdx == IdxW'(DataBits - 1)) rxState <= RX_STOP;
        end else rxCnt <= rxCnt + CntW'(1);
        RX_STOP: if (rxCnt == lastTick) begin
          rxCnt   <= '0;
          rxState <= (!rxSync && !rxSawOne) ? RX_BREAK : RX_IDLE;
        end else rxCnt <= rxCnt + CntW'(1);
        RX_BREAK: if (rxSync) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_xcvr_dp.sv
module uart_xcvr_dp
  import uart_xcvr_pkg::*;
#(
  parameter int DataBits = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DataBits-1:0] wrData,
  input  logic                rxLine,
  input  xcvrStrobes_t        stb,
  output logic [DataBits-1:0] rdData,
  output logic                txLine,
  output logic                rxSync,
  output logic                txHoldFull,
  output logic                txReady,
  output logic                txEmpty,
  output logic                rxReady,
  output logic                overrun,
  output logic                breakDet,
  output logic [1:0]          ratioSel
);
  localparam int FrameBits = DataBits + 2;

  logic [DataBits-1:0]  txHold, rxShiftReg, rxBuf, status;
  logic [FrameBits-1:0] txShiftReg;
  logic                 rxMeta;
  logic                 dataWr, ctrlWr, dataRd;

  always_comb begin
    dataWr    = wrEn && !ctrlSel;
    ctrlWr    = wrEn && ctrlSel;
    dataRd    = rdEn && !ctrlSel;
    txReady   = !txHoldFull;
    txEmpty   = !stb.txActive;
    txLine    = stb.txActive ? txShiftReg[0] : 1'b1;
    status    = '0;
    status[0] = txReady;
    status[1] = rxReady;
    status[2] = txEmpty;
    status[3] = overrun;
    status[4] = breakDet;
    rdData    = ctrlSel ? status : rxBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold     <= '0;
      txHoldFull <= 1'b0;
      txShiftReg <= '1;
      rxShiftReg <= '0;
      rxBuf      <= '0;
      rxReady    <= 1'b0;
      overrun    <= 1'b0;
      breakDet   <= 1'b0;
      ratioSel   <= 2'b10;
      rxMeta     <= 1'b1;
      rxSync     <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      if (ctrlWr) ratioSel <= wrData[1:0];
      if (dataWr) begin
        txHold     <= wrData;
        txHoldFull <= 1'b1;
      end else if (stb.txLoad) begin
        txHoldFull <= 1'b0;
      end
      if (stb.txLoad)       txShiftReg <= {1'b1, txHold, 1'b0};
      else if (stb.txShift) txShiftReg <= {1'b1, txShiftReg[FrameBits-1:1]};
      if (stb.rxShift) rxShiftReg <= {rxSync, rxShiftReg[DataBits-1:1]};
      if (stb.rxDeliver) begin
        rxBuf   <= rxShiftReg;
        rxReady <= 1'b1;
        overrun <= !dataRd && (overrun || rxReady);
      end else if (dataRd) begin
        rxReady <= 1'b0;
        overrun <= 1'b0;
      end
      if (stb.rxBreakSet)      breakDet <= 1'b1;
      else if (stb.rxBreakClr) breakDet <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DataBits = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serTick,
  input  logic                ctrlSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DataBits-1:0] wrData,
  output logic [DataBits-1:0] rdData,
  output logic                txLine,
  input  logic                rxLine,
  output logic                txReady,
  output logic                txEmpty,
  output logic                rxReady,
  output logic                overrun,
  output logic                breakDet
);
  xcvrStrobes_t stb;
  logic         rxSync, txHoldFull;
  logic [1:0]   ratioSel;

  uart_xcvr_ctl #(.DataBits(DataBits)) u_ctl (
    .clk(clk), .rstN(rstN), .serTick(serTick), .ratioSel(ratioSel),
    .txHoldFull(txHoldFull), .rxSync(rxSync), .stb(stb)
  );

  uart_xcvr_dp #(.DataBits(DataBits)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlSel(ctrlSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rxLine(rxLine), .stb(stb), .rdData(rdData),
    .txLine(txLine), .rxSync(rxSync), .txHoldFull(txHoldFull),
    .txReady(txReady), .txEmpty(txEmpty), .rxReady(rxReady),
    .overrun(overrun), .breakDet(breakDet), .ratioSel(ratioSel)
  );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rstN,
  input logic serTick,
  input logic ctrlSel,
  input logic rdEn,
  input logic txLine,
  input logic txReady,
  input logic txEmpty,
  input logic rxReady,
  input logic overrun,
  input logic breakDet
);
  AST_TX_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!txReady && txEmpty && serTick) |=> !txEmpty); // R3
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txLine); // R4
  AST_RX_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(serTick)); // R6
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !ctrlSel && !serTick) |=> !rxReady); // R6
  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxReady)); // R9
  AST_BREAK_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> !$rose(rxReady)); // R10
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk(clk), .rstN(rstN), .serTick(serTick), .ctrlSel(ctrlSel), .rdEn(rdEn),
  .txLine(txLine), .txReady(txReady), .txEmpty(txEmpty), .rxReady(rxReady),
  .overrun(overrun), .breakDet(breakDet)
);

// File: tb/uart_xcvr_tb.sv
`timescale 1ns/1ps
module uart_xcvr_tb;
  localparam int Div = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serTick = 1'b0;
  logic       ctrlSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       txLine, rxLine = 1'b1;
  logic       txReady, txEmpty, rxReady, overrun, breakDet;
  logic [1:0] divCnt = '0;

  int errors = 0;
  int checks = 0;
  int bitClks = 16 * Div;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    divCnt  <= divCnt + 2'd1;
    serTick <= (divCnt == 2'(Div - 1));
  end

  uart_xcvr u_dut (
    .clk(clk), .rstN(rstN), .serTick(serTick), .ctrlSel(ctrlSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .txLine(txLine), .rxLine(rxLine), .txReady(txReady), .txEmpty(txEmpty),
    .rxReady(rxReady), .overrun(overrun), .breakDet(breakDet)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); ctrlSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic sel, output logic [7:0] d);
    @(negedge clk); ctrlSel = sel; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic setRatio(input logic [1:0] code, input int ticks);
    cpuWrite(1'b1, {6'b0, code});
    bitClks = ticks * Div;
  endtask

  task automatic alignTick;
    @(negedge clk);
    while (serTick !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rxBit(input logic v);
    rxLine = v;
    repeat (bitClks) @(negedge clk);
  endtask

  // driver: pushes the expected byte and plays the frame
  task automatic sendRx(input logic [7:0] d);
    rxQ.push_back(d);
    alignTick();
    rxBit(1'b0);
    for (int i = 0; i < 8; i++) rxBit(d[i]);
    rxBit(1'b1);
  endtask

  task automatic readRx(input string tag);
    logic [7:0] d, e;
    cpuRead(1'b0, d);
    e = (rxQ.size() > 0) ? rxQ.pop_front() : 8'hxx;
    check(tag, d, e);
  endtask

  task automatic sendTx(input logic [7:0] d);
    txQ.push_back(d);
    cpuWrite(1'b0, d);
  endtask

  task automatic waitTxIdle;
    int n = 0;
    while (!(txEmpty && txReady) && n < 40000) begin
      @(negedge clk); n++;
    end
    repeat (8) @(negedge clk);
  endtask

  // monitor: decodes frames on txLine and compares with the queue
  initial begin
    logic [7:0] got, exp;
    wait (rstN === 1'b1);
    forever begin
      @(negedge txLine);
      repeat (bitClks / 2) @(negedge clk);
      check("R4 start bit", {7'b0, txLine}, 8'h00);
      for (int i = 0; i < 8; i++) begin
        repeat (bitClks) @(negedge clk);
        got[i] = txLine;
      end
      repeat (bitClks) @(negedge clk);
      check("R4 stop bit", {7'b0, txLine}, 8'h01);
      check("R5 txEmpty low in stop bit", {7'b0, txEmpty}, 8'h00);
      exp = (txQ.size() > 0) ? txQ.pop_front() : 8'hxx;
      check("R4/R11 tx byte LSB first", got, exp);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cpuRead(1'b1, s);
    check("R1 reset status", s, 8'h05);
    check("R1 idle line", {7'b0, txLine}, 8'h01);

    // R3/R4/R5 transmit at the reset ratio (16x)
    sendTx(8'hA5);
    check("R3 txReady low after write", {7'b0, txReady}, 8'h00);
    repeat (Div + 2) @(negedge clk);
    check("R3 holding freed after load", {7'b0, txReady}, 8'h01);
    check("R5 txEmpty low while sending", {7'b0, txEmpty}, 8'h00);
    sendTx(8'h3C);
    repeat (10) @(negedge clk);
    check("R3 second byte waits in holding", {7'b0, txReady}, 8'h00);
    waitTxIdle();
    cpuRead(1'b1, s);
    check("R5 idle status after frames", s, 8'h05);

    // R11 transmit at 1x and 64x
    setRatio(2'b01, 1);
    sendTx(8'h81);
    waitTxIdle();
    setRatio(2'b11, 64);
    sendTx(8'h5A);
    waitTxIdle();
    setRatio(2'b10, 16);

    // R2/R6 receive and register select
    sendRx(8'hC3);
    cpuRead(1'b1, s);
    check("R2 R6 status shows rxReady", s, 8'h07);
    readRx("R2 R6 data read");
    cpuRead(1'b1, s);
    check("R6 read clears rxReady", s, 8'h05);

    // R7 short glitch is rejected at mid-bit
    alignTick();
    rxLine = 1'b0;
    repeat (4 * Div) @(negedge clk);
    rxLine = 1'b1;
    repeat (bitClks * 11) @(negedge clk);
    cpuRead(1'b1, s);
    check("R7 glitch gives no byte", s, 8'h05);
    sendRx(8'hE7);
    readRx("R7 frame after glitch");

    // R9 overrun
    sendRx(8'h11);
    sendRx(8'h22);
    cpuRead(1'b1, s);
    check("R9 overrun flagged", s, 8'h0F);
    void'(rxQ.pop_front());
    readRx("R9 newest byte kept");
    cpuRead(1'b1, s);
    check("R9 data read clears overrun", s, 8'h05);

    // R10 break
    alignTick();
    rxLine = 1'b0;
    repeat (bitClks * 11) @(negedge clk);
    cpuRead(1'b1, s);
    check("R10 break set, no byte", s, 8'h15);
    rxLine = 1'b1;
    repeat (bitClks * 2) @(negedge clk);
    cpuRead(1'b1, s);
    check("R10 break clears on high line", s, 8'h05);
    sendRx(8'h5A);
    readRx("R10 receiver recovers");

    // R8 1x: single low tick accepted as start
    setRatio(2'b01, 1);
    sendRx(8'hFF);
    cpuRead(1'b1, s);
    check("R8 one-tick start accepted", s, 8'h07);
    readRx("R8 byte in 1x");
    sendRx(8'h96);
    readRx("R8 pattern in 1x");

    // R11 receive at 64x
    setRatio(2'b11, 64);
    sendRx(8'h2D);
    readRx("R11 byte in 64x");

    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule